// File: doc/BRIEF.md
# I2C Register-Access Target

This block is the serial front end of a small register space. It watches an I2C bus through oversampled, synchronized and glitch-filtered copies of SCL and SDA, answers to a 7-bit identification byte whose upper four bits are fixed at 1010 and whose next three bits come from strap pins, and turns the traffic that follows into single-byte requests on a simple internal register bus. The register contents themselves live outside the block.

A write transfer carries a register address byte and then any number of data bytes. Each data byte becomes one write strobe at the current pointer, and the pointer then steps forward. A read transfer first sets the pointer with a write phase, then issues a repeated START and the identification byte with the read bit set. Bytes are then streamed from the pointer for as long as the controller acknowledges. The pointer steps from the last location (8 by default) back to 0. The block only ever pulls SDA low and never drives it high. It ignores the bus until a power-up ready input is asserted.

Top module: `i2c_regbus_target`

## Requirements
- R1: Out of reset, sda_pull, reg_wr, reg_rd and stop_pulse are all 0.
- R2: An identification byte is accepted only when bits 7:4 are 1010 and bits 3:1 equal strap_addr (bit 0 = 1 for read, 0 for write). On a mismatch the block leaves SDA released in the ninth clock and makes no register access until the next START.
- R3: The block pulls SDA low during the ninth SCL clock after an accepted identification byte, after the address byte, and after every data byte of a write. At no other time does it pull SDA, except to send read data.
- R4: Each write data byte, taken MSB first on SCL rising edges, gives exactly one single-cycle reg_wr with reg_addr equal to the pointer and reg_wdata equal to the byte. The pointer then advances.
- R5: After a repeated START with a read identification byte, bytes are sent MSB first from reg_rdata at the pointer. Each byte is fetched with one reg_rd pulse during the preceding acknowledge clock. Bytes continue while the controller acknowledges, and a controller NACK ends the transfer.
- R6: The pointer advances from LAST_ADDR (8) to 0 in both reads and writes. An address byte above LAST_ADDR loads 0, so reg_addr never exceeds LAST_ADDR.
- R7: While pwr_ready is 0, START conditions are ignored and SDA is released.
- R8: A STOP condition (SDA rising while SCL is high) gives a one-cycle stop_pulse, releases SDA and returns the block to idle.
- R9: A pulse on SCL or SDA shorter than FILT_LEN clock cycles has no effect on the transfer.
- R10: reg_wr and reg_rd are never high in the same cycle, and neither stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_ready | input | 1 | High once power-up recall is done; the bus is ignored while low |
| strap_addr | input | 3 | Strap pins, bits 3:1 of the identification byte |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain enable) |
| reg_addr | output | PW (4) | Register pointer presented with a strobe |
| reg_wdata | output | 8 | Write data, valid with reg_wr |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe; reg_rdata is taken in the same cycle |
| reg_rdata | input | 8 | Read data for reg_addr |
| stop_pulse | output | 1 | One-cycle pulse on a STOP condition |

## Verification
Every response is due a fixed number of clocks after an SCL edge on the pins: about two synchronizer stages, FILT_LEN filter samples and one state register, so about six cycles. The bench moves SDA a full quarter SCL period (12 clocks) after each falling edge and reads SDA at the middle of the high phase, so it never samples while the target's drive is changing. Register-bus effects (write strobes, read strobes, stop pulses) are counted on every clock and compared after the STOP that closes each transfer, when all of them must have occurred.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } tgt_state_e;

  typedef enum logic [1:0] {
    K_ID,
    K_ADDR,
    K_DATA
  } rx_kind_e;

  localparam logic [3:0] ID_PREFIX = 4'b1010;

  function automatic logic id_match(input logic [7:0] b, input logic [2:0] strap);
    return (b[7:4] == ID_PREFIX) && (b[3:1] == strap);
  endfunction

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3,
  localparam int CW = $clog2(FILT_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_filt
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          run_cnt;
  logic                   line_s;

  assign line_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_filt <= 1'b1;
      run_cnt   <= '0;
    end else if (line_s != line_filt) begin
      if (run_cnt == CW'(FILT_LEN - 1)) begin
        line_filt <= line_s;
        run_cnt   <= '0;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end else begin
      run_cnt <= '0;
    end
  end

  // R9
  filt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(line_filt) |-> ($past(line_s) == line_filt));

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_evt = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_evt  = scl_f & scl_q & ~sda_q & sda_f;

  // R8
  start_stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_evt && stop_evt));

  // R9
  edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((scl_rise || scl_fall) && (start_evt || stop_evt)));

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import i2c_tgt_pkg::*;
#(
  parameter int LAST_ADDR = 8,
  localparam int PW = $clog2(LAST_ADDR + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_ready,
  input  logic [2:0]    strap_addr,
  input  logic          sda_f,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_evt,
  input  logic          stop_evt,
  output logic          sda_pull,
  output logic [PW-1:0] reg_addr,
  output logic [7:0]    reg_wdata,
  output logic          reg_wr,
  output logic          reg_rd,
  input  logic [7:0]    reg_rdata,
  output logic          stop_pulse
);

  function automatic logic [PW-1:0] ptr_advance(input logic [PW-1:0] p);
    return (p >= PW'(LAST_ADDR)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PW-1:0] ptr_load(input logic [7:0] b);
    return (b > 8'(LAST_ADDR)) ? '0 : b[PW-1:0];
  endfunction

  tgt_state_e    state;
  rx_kind_e      kind;
  logic [3:0]    bit_cnt;
  logic [7:0]    rx_sh;
  logic [7:0]    tx_sh;
  logic          rd_mode;
  logic          mack_ok;
  logic [PW-1:0] ptr;

  assign reg_addr = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      kind       <= K_ID;
      bit_cnt    <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      rd_mode    <= 1'b0;
      mack_ok    <= 1'b0;
      ptr        <= '0;
      sda_pull   <= 1'b0;
      reg_wdata  <= '0;
      reg_wr     <= 1'b0;
      reg_rd     <= 1'b0;
      stop_pulse <= 1'b0;
    end else begin
      reg_wr     <= 1'b0;
      reg_rd     <= 1'b0;
      stop_pulse <= 1'b0;
      if (reg_rd) tx_sh <= reg_rdata;
      if (!pwr_ready) begin
        state    <= ST_IDLE;
        sda_pull <= 1'b0;
      end else if (stop_evt) begin
        state      <= ST_IDLE;
        sda_pull   <= 1'b0;
        stop_pulse <= 1'b1;
      end else if (start_evt) begin
        state    <= ST_RX;
        kind     <= K_ID;
        bit_cnt  <= '0;
        sda_pull <= 1'b0;
      end else begin
        unique case (state)
          ST_RX: begin
            if (scl_rise && bit_cnt < 4'd8) begin
              rx_sh   <= {rx_sh[6:0], sda_f};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              unique case (kind)
                K_ID: begin
                  if (id_match(rx_sh, strap_addr)) begin
                    sda_pull <= 1'b1;
                    state    <= ST_ACK;
                    rd_mode  <= rx_sh[0];
                    reg_rd   <= rx_sh[0];
                  end else begin
                    state <= ST_IDLE;
                  end
                end
                K_ADDR: begin
                  ptr      <= ptr_load(rx_sh);
                  sda_pull <= 1'b1;
                  state    <= ST_ACK;
                end
                default: begin
                  reg_wr    <= 1'b1;
                  reg_wdata <= rx_sh;
                  sda_pull  <= 1'b1;
                  state     <= ST_ACK;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (kind == K_DATA) ptr <= ptr_advance(ptr);
              if (kind == K_ID && rd_mode) begin
                state    <= ST_TX;
                sda_pull <= ~tx_sh[7];
              end else begin
                state    <= ST_RX;
                sda_pull <= 1'b0;
                kind     <= (kind == K_ID) ? K_ADDR : K_DATA;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bit_cnt == 4'd7) begin
                sda_pull <= 1'b0;
                state    <= ST_MACK;
              end else begin
                sda_pull <= ~tx_sh[6];
                tx_sh    <= {tx_sh[6:0], 1'b0};
                bit_cnt  <= bit_cnt + 1'b1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mack_ok <= ~sda_f;
              if (!sda_f) begin
                ptr    <= ptr_advance(ptr);
                reg_rd <= 1'b1;
              end
            end else if (scl_fall) begin
              bit_cnt <= '0;
              if (mack_ok) begin
                state    <= ST_TX;
                sda_pull <= ~tx_sh[7];
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R7
  idle_when_unready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ready |=> (!sda_pull && state == ST_IDLE));

  // R8
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && pwr_ready) |=> (stop_pulse && !sda_pull && state == ST_IDLE));

  // R3
  pull_only_ack_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull |-> (state == ST_ACK || state == ST_TX));

  // R4
  wr_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> (state == ST_ACK && kind == K_DATA));

  // R6
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr <= PW'(LAST_ADDR));

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));

  // R10
  wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

endmodule

// File: rtl/i2c_regbus_target.sv
module i2c_regbus_target #(
  parameter int LAST_ADDR   = 8,
  parameter int FILT_LEN    = 3,
  parameter int SYNC_STAGES = 2,
  localparam int PW = $clog2(LAST_ADDR + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_ready,
  input  logic [2:0]    strap_addr,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          sda_pull,
  output logic [PW-1:0] reg_addr,
  output logic [7:0]    reg_wdata,
  output logic          reg_wr,
  output logic          reg_rd,
  input  logic [7:0]    reg_rdata,
  output logic          stop_pulse
);

  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines;
  logic [NLINES-1:0] filt_lines;
  logic scl_rise, scl_fall, start_evt, stop_evt;

  assign raw_lines = {sda_in, scl_in};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    i2c_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_filt (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_in  (raw_lines[g]),
      .line_filt(filt_lines[g])
    );
  end

  i2c_bus_events u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (filt_lines[0]),
    .sda_f    (filt_lines[1]),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt)
  );

  i2c_target_fsm #(
    .LAST_ADDR(LAST_ADDR)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_ready (pwr_ready),
    .strap_addr(strap_addr),
    .sda_f     (filt_lines[1]),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .sda_pull  (sda_pull),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata),
    .stop_pulse(stop_pulse)
  );

endmodule

// File: tb/tb_i2c_regbus_target.sv
module tb_i2c_regbus_target;

  localparam int Q = 12;
  localparam logic [2:0] STRAP = 3'b101;
  localparam int NV = 6;
  localparam logic [15:0] VEC [NV] = '{16'h00A5, 16'h03FF, 16'h085A,
                                       16'h0500, 16'h0181, 16'h063C};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_ready = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_pull, reg_wr, reg_rd, stop_pulse;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic sda_bus;

  logic [7:0] mem [0:8];
  logic [7:0] wbuf [0:15];
  logic [7:0] rbuf [0:15];
  int wr_cnt = 0, rd_cnt = 0, stop_cnt = 0, bad_strobe = 0;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  assign sda_bus   = m_sda & ~sda_pull;
  assign reg_rdata = (reg_addr <= 4'd8) ? mem[reg_addr] : 8'h00;

  i2c_regbus_target dut (
    .clk(clk), .rst_n(rst_n), .pwr_ready(pwr_ready), .strap_addr(STRAP),
    .scl_in(m_scl), .sda_in(sda_bus), .sda_pull(sda_pull),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .stop_pulse(stop_pulse)
  );

  logic wr_q = 1'b0, rd_q = 1'b0;
  always @(posedge clk) begin
    if (reg_wr && reg_addr <= 4'd8) mem[reg_addr] <= reg_wdata;
    if (reg_wr) wr_cnt <= wr_cnt + 1;
    if (reg_rd) rd_cnt <= rd_cnt + 1;
    if (stop_pulse) stop_cnt <= stop_cnt + 1;
    if ((reg_wr && reg_rd) || (reg_wr && wr_q) || (reg_rd && rd_q)) bad_strobe <= bad_strobe + 1;
    wr_q <= reg_wr;
    rd_q <= reg_rd;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic wq(input int n = Q);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic send_bit(input logic b, input logic glitch);
    m_sda = b; wq(); m_scl = 1'b1;
    if (glitch && b) begin
      wq(5); m_sda = 1'b0; wq(2); m_sda = 1'b1; wq(Q - 7);
    end else wq();
    wq(); m_scl = 1'b0; wq();
  endtask

  task automatic recv_bit(output logic b);
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); b = sda_bus; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] v, input logic glitch, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(v[i], glitch);
    recv_bit(a);
    ack = ~a;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin recv_bit(b); v[i] = b; end
    send_bit(~mack, 1'b0);
  endtask

  task automatic do_write(input logic [2:0] a3, input logic [7:0] ra, input int n,
                          input logic glitch, output logic all_ack);
    logic a;
    all_ack = 1'b1;
    i2c_start();
    send_byte({4'b1010, a3, 1'b0}, 1'b0, a); all_ack &= a;
    send_byte(ra, 1'b0, a); all_ack &= a;
    for (int i = 0; i < n; i++) begin send_byte(wbuf[i], glitch, a); all_ack &= a; end
    i2c_stop();
    wq(4);
  endtask

  task automatic do_read(input logic [7:0] ra, input int n, output logic all_ack);
    logic a;
    logic [7:0] v;
    all_ack = 1'b1;
    i2c_start();
    send_byte({4'b1010, STRAP, 1'b0}, 1'b0, a); all_ack &= a;
    send_byte(ra, 1'b0, a); all_ack &= a;
    i2c_start();
    send_byte({4'b1010, STRAP, 1'b1}, 1'b0, a); all_ack &= a;
    for (int i = 0; i < n; i++) begin recv_byte(i != n - 1, v); rbuf[i] = v; end
    i2c_stop();
    wq(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic ok;
    int w0, r0, s0;
    for (int i = 0; i <= 8; i++) mem[i] = 8'h00;
    wq(5);
    // R1 reset state
    check("R1 sda_pull", int'(sda_pull), 0);
    check("R1 reg_wr", int'(reg_wr), 0);
    check("R1 reg_rd", int'(reg_rd), 0);
    check("R1 stop_pulse", int'(stop_pulse), 0);
    rst_n = 1'b1;
    wq(5);

    // R7 no response while pwr_ready is low
    wbuf[0] = 8'h77;
    do_write(STRAP, 8'h02, 1, 1'b0, ok);
    check("R7 ack while unready", int'(ok), 0);
    check("R7 writes while unready", wr_cnt, 0);
    check("R7 stop pulses while unready", stop_cnt, 0);
    pwr_ready = 1'b1;
    wq(5);

    // vector table: R3 R4 R5 R8
    for (int v = 0; v < NV; v++) begin
      w0 = wr_cnt; s0 = stop_cnt; r0 = rd_cnt;
      wbuf[0] = VEC[v][7:0];
      do_write(STRAP, VEC[v][15:8], 1, 1'b0, ok);
      check("R3 write acks", int'(ok), 1);
      check("R4 one write strobe", wr_cnt - w0, 1);
      check("R4 stored byte", int'(mem[VEC[v][11:8]]), int'(VEC[v][7:0]));
      check("R8 stop pulse after write", stop_cnt - s0, 1);
      do_read(VEC[v][15:8], 1, ok);
      check("R3 read setup acks", int'(ok), 1);
      check("R5 read byte", int'(rbuf[0]), int'(VEC[v][7:0]));
      check("R5 one fetch", rd_cnt - r0, 1);
    end

    // R6 write wrap from 7: 7, 8, 0
    w0 = wr_cnt;
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    do_write(STRAP, 8'h07, 3, 1'b0, ok);
    check("R4 three strobes", wr_cnt - w0, 3);
    check("R6 write loc7", int'(mem[7]), 8'h11);
    check("R6 write loc8", int'(mem[8]), 8'h22);
    check("R6 write wrap loc0", int'(mem[0]), 8'h33);

    // R6 read wrap from 8, R5 multi-byte fetch count
    r0 = rd_cnt;
    do_read(8'h08, 3, ok);
    check("R6 read loc8", int'(rbuf[0]), 8'h22);
    check("R6 read wrap loc0", int'(rbuf[1]), 8'h33);
    check("R5 read loc1", int'(rbuf[2]), 8'h81);
    check("R5 fetch per byte", rd_cnt - r0, 3);

    // R6 out-of-range address byte loads 0
    wbuf[0] = 8'hC3;
    do_write(STRAP, 8'h0C, 1, 1'b0, ok);
    check("R6 high address to loc0", int'(mem[0]), 8'hC3);

    // R2 strap mismatch
    w0 = wr_cnt;
    wbuf[0] = 8'hEE;
    do_write(3'b100, 8'h04, 1, 1'b0, ok);
    check("R2 mismatch nack", int'(ok), 0);
    check("R2 no write on mismatch", wr_cnt - w0, 0);
    check("R2 loc4 untouched", int'(mem[4]), 8'h00);

    // R9 short SDA pulses while SCL high are ignored
    w0 = wr_cnt;
    wbuf[0] = 8'hFF; wbuf[1] = 8'hB7;
    do_write(STRAP, 8'h02, 2, 1'b1, ok);
    check("R9 acks through glitches", int'(ok), 1);
    check("R9 strobes through glitches", wr_cnt - w0, 2);
    check("R9 loc2", int'(mem[2]), 8'hFF);
    check("R9 loc3", int'(mem[3]), 8'hB7);

    // R10 strobe shape, R8 idle release
    check("R10 strobe overlap or width", bad_strobe, 0);
    check("R8 released after stop", int'(sda_pull), 0);
    finish_run();
  end

endmodule